// File: doc/BRIEF.md
# Debounced Switch Reporter with Byte Command Port

This block watches five active-low switch pins and treats them as one group. On every sample tick it reads the inverted pins into a byte word, so a pin held low reads as a 1 and the top three bits are always zero. The block reports a group value only after that value has held without change for a fixed number of sample ticks. It then sends the value as one byte on an outgoing valid/ready byte stream, and only when it differs from the value it last reported.

An incoming valid/ready byte stream carries single-character commands. The commands drive two active-low outputs and can ask for the last reported value. Both byte streams are meant to sit next to a UART transmitter and receiver. A two-entry queue holds outgoing bytes, so a change report and a query reply that fall in the same cycle are both kept.

Top module: `pin_debounce_reporter`

## Requirements
- R1: The sampled word is `{3'b000, ~pins_n}`. Every byte sent has bits 7 to 5 at zero, and a reported byte equals the inverted pin levels.
- R2: A sample that differs from the previous sample reloads a hold counter to HOLD_TICKS (default 100). The counter then steps down by one per sample tick until it reaches zero. A report becomes due once the counter is zero.
- R3: Pins that change again before the hold counter reaches zero produce no report of the passing values. A single report follows once the final value has held for HOLD_TICKS ticks.
- R4: A report is sent only when the settled word differs from the last reported value. A value that leaves and comes back before settling sends nothing.
- R5: A received `?` (0x3F) sends one byte that holds the last reported value.
- R6: A received `a` (0x61) drives `drv_n[0]` low, and `A` (0x41) drives it high.
- R7: A received `b` (0x62) drives `drv_n[1]` low, and `B` (0x42) drives it high.
- R8: After reset both `drv_n` bits are high, `tx_valid` is low and the reported value is zero. No report is sent until a pin changes.
- R9: Any received byte other than the five command codes leaves `drv_n` unchanged and sends nothing.
- R10: If a report falls due in the same cycle that `?` is accepted, both bytes are queued: the report first, then the reply. Both carry the newly reported value.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds steady.
- R12: The hold counter changes only on sample ticks, which come once every TICK_DIV clocks.
- R13: `rx_ready` is high only while the outgoing queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_n | input | 5 | Active-low switch pins |
| rx_data | input | 8 | Incoming command byte |
| rx_valid | input | 1 | Incoming byte is valid |
| rx_ready | output | 1 | Block accepts an incoming byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte is valid |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| drv_n | output | 2 | Active-low command-driven outputs |

## Verification
Two functions can fire in the same cycle: a change report falling due, and an accepted `?` query. The bench watches its own behavioural model to find the clock edge where the hold counter has reached zero with an unreported value waiting. It presents `?` on that edge while holding `tx_ready` low. It then requires that the queue be full, that `rx_ready` drop, and that the two bytes that drain be the report followed by a reply carrying the same new value.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam int PIN_W = 5;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_QUERY = 8'h3F;
  localparam logic [7:0] CMD_ON0   = 8'h61;
  localparam logic [7:0] CMD_OFF0  = 8'h41;
  localparam logic [7:0] CMD_ON1   = 8'h62;
  localparam logic [7:0] CMD_OFF1  = 8'h42;

  typedef enum logic [2:0] {
    OP_NONE, OP_QUERY, OP_ON0, OP_OFF0, OP_ON1, OP_OFF1
  } cmd_op_e;

  // Active-low pins to a zero-extended active-high word.
  function automatic logic [BYTE_W-1:0] pin_word(input logic [PIN_W-1:0] p_n);
    return {{(BYTE_W-PIN_W){1'b0}}, ~p_n};
  endfunction

  function automatic cmd_op_e decode_cmd(input logic [7:0] b);
    case (b)
      CMD_QUERY: return OP_QUERY;
      CMD_ON0:   return OP_ON0;
      CMD_OFF0:  return OP_OFF0;
      CMD_ON1:   return OP_ON1;
      CMD_OFF1:  return OP_OFF1;
      default:   return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pdr_tick.sv
module pdr_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      assign tick = (div_q == LAST);
      always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pdr_debounce.sv
module pdr_debounce
  import pdr_pkg::*;
#(
  parameter int HOLD_TICKS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PIN_W-1:0]  pins_n,
  input  logic              can_push,
  output logic [7:0]        settled,
  output logic [7:0]        reported,
  output logic              rep_evt,
  output logic              reload_evt,
  output logic              cnt_zero
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_TICKS);

  logic [7:0]    sample_w;
  logic [7:0]    prev_q;
  logic [7:0]    rep_q;
  logic [CW-1:0] cnt_q;

  assign sample_w   = pin_word(pins_n);
  assign reload_evt = tick && (sample_w != prev_q);
  assign cnt_zero   = (cnt_q == '0);
  assign rep_evt    = cnt_zero && (prev_q != rep_q) && can_push;
  assign settled    = prev_q;
  assign reported   = rep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else if (reload_evt) begin
      prev_q <= sample_w;
      cnt_q  <= RELOAD;
    end else if (tick && !cnt_zero) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rep_q <= '0;
    else if (rep_evt) rep_q <= prev_q;
  end
endmodule

// File: rtl/pdr_cmd.sv
module pdr_cmd
  import pdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [7:0] rx_data,
  output logic       query_evt,
  output logic [1:0] drv_n
);
  cmd_op_e op;
  assign op        = accept ? decode_cmd(rx_data) : OP_NONE;
  assign query_evt = (op == OP_QUERY);

  always_ff @(posedge clk) begin
    if (!rst_n) drv_n <= 2'b11;
    else begin
      case (op)
        OP_ON0:  drv_n[0] <= 1'b0;
        OP_OFF0: drv_n[0] <= 1'b1;
        OP_ON1:  drv_n[1] <= 1'b0;
        OP_OFF1: drv_n[1] <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pdr_txq.sv
module pdr_txq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_a,
  input  logic [7:0] data_a,
  input  logic       push_b,
  input  logic [7:0] data_b,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       empty,
  output logic       full
);
  logic [7:0] s0_q, s1_q, s0_d, s1_d;
  logic [1:0] n_q, n_d;
  logic       pop;

  assign empty    = (n_q == 2'd0);
  assign full     = (n_q == 2'd2);
  assign tx_valid = !empty;
  assign tx_data  = s0_q;
  assign pop      = tx_valid && tx_ready;

  always_comb begin
    s0_d = s0_q;
    s1_d = s1_q;
    n_d  = n_q;
    if (pop) begin
      s0_d = s1_q;
      n_d  = n_d - 2'd1;
    end
    if (push_a) begin
      if (n_d == 2'd0) s0_d = data_a;
      else             s1_d = data_a;
      n_d = n_d + 2'd1;
    end
    if (push_b) begin
      if (n_d == 2'd0) s0_d = data_b;
      else             s1_d = data_b;
      n_d = n_d + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q  <= '0;
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      n_q  <= n_d;
      s0_q <= s0_d;
      s1_q <= s1_d;
    end
  end
endmodule

// File: rtl/pin_debounce_reporter.sv
module pin_debounce_reporter
  import pdr_pkg::*;
#(
  parameter int TICK_DIV   = 1000,
  parameter int HOLD_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pins_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [1:0]       drv_n
);
  logic       tick;
  logic       rep_evt, reload_evt, cnt_zero, query_evt;
  logic       q_empty, q_full, accept;
  logic [7:0] settled, reported, reply_w;

  pdr_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pdr_debounce #(.HOLD_TICKS(HOLD_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pins_n(pins_n),
    .can_push(!q_full), .settled(settled), .reported(reported),
    .rep_evt(rep_evt), .reload_evt(reload_evt), .cnt_zero(cnt_zero)
  );

  assign rx_ready = q_empty;
  assign accept   = rx_valid && rx_ready;

  pdr_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rx_data(rx_data),
    .query_evt(query_evt), .drv_n(drv_n)
  );

  // The reply carries the value that is reported after this cycle.
  assign reply_w = rep_evt ? settled : reported;

  pdr_txq u_q (
    .clk(clk), .rst_n(rst_n),
    .push_a(rep_evt), .data_a(settled),
    .push_b(query_evt), .data_b(reply_w),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .empty(q_empty), .full(q_full)
  );
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       reload_evt,
  input logic       rep_evt,
  input logic       query_evt,
  input logic       cnt_zero,
  input logic       q_full,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic [1:0] drv_n
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data[7:5] == 3'b000));

  assert_reload_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> !cnt_zero);

  assert_on0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_data == 8'h61) |=> !drv_n[0]);

  assert_off1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_data == 8'h42) |=> drv_n[1]);

  assert_both_queued_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_evt && query_evt && !tx_valid) |=> q_full);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_tick_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_zero));

  assert_ready_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !tx_valid);
endmodule

bind pin_debounce_reporter pdr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reload_evt(reload_evt),
  .rep_evt(rep_evt), .query_evt(query_evt), .cnt_zero(cnt_zero),
  .q_full(q_full), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .drv_n(drv_n)
);

// File: tb/sim_pin_debounce_reporter.sv
`timescale 1ns/1ps
module sim_pin_debounce_reporter;
  localparam int DIV  = 4;
  localparam int HOLD = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] pins_n = 5'h1F;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic       tx_ready = 1'b1;
  logic       rx_ready, tx_valid;
  logic [7:0] tx_data;
  logic [1:0] drv_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pin_debounce_reporter #(.TICK_DIV(DIV), .HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .pins_n(pins_n), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .drv_n(drv_n)
  );

  // Behavioural reference model
  int         m_div, m_cnt;
  logic [7:0] m_prev, m_rep;
  logic [1:0] m_drv;
  logic [7:0] mq[$];
  logic [7:0] got[$];

  always @(posedge clk) begin
    int sz;
    bit tk, rep, acc;
    logic [7:0] w;
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_prev = 8'h00; m_rep = 8'h00;
      m_drv = 2'b11; mq.delete();
    end else begin
      sz  = mq.size();
      tk  = (m_div == DIV - 1);
      m_div = tk ? 0 : m_div + 1;
      rep = (m_cnt == 0) && (m_prev != m_rep) && (sz < 2);
      acc = rx_valid && (sz == 0);
      if (sz > 0 && tx_ready) void'(mq.pop_front());
      if (rep) begin m_rep = m_prev; mq.push_back(m_prev); end
      if (acc) begin
        case (rx_data)
          8'h3F: mq.push_back(m_rep);
          8'h61: m_drv[0] = 1'b0;
          8'h41: m_drv[0] = 1'b1;
          8'h62: m_drv[1] = 1'b0;
          8'h42: m_drv[1] = 1'b1;
          default: ;
        endcase
      end
      if (tk) begin
        w = {3'b000, ~pins_n};
        if (w != m_prev) begin m_prev = w; m_cnt = HOLD; end
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
      end
    end
  end

  always @(posedge clk)
    if (rst_n && tx_valid && tx_ready) got.push_back(tx_data);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Cycle compare against the model (R2 R3 R4 R5 R10 R12 R13 timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tx_valid == (mq.size() != 0), "R12", "tx_valid vs model",
            int'(tx_valid), int'(mq.size() != 0));
      if (tx_valid && mq.size() != 0)
        check(tx_data == mq[0], "R2", "tx_data vs model", tx_data, mq[0]);
      check(drv_n == m_drv, "R6", "drv_n vs model", drv_n, m_drv);
      check(rx_ready == (mq.size() == 0), "R13", "rx_ready vs model",
            int'(rx_ready), int'(mq.size() == 0));
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (mq.size() != 0) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual 0 expected 1");
    finish_run();
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(drv_n == 2'b11, "R8", "drv_n after reset", drv_n, 3);
    check(!tx_valid, "R8", "tx_valid after reset", int'(tx_valid), 0);
    wait_ticks(HOLD + 20);
    check(got.size() == 0, "R8", "no report without change", got.size(), 0);

    // R2 / R1: press pin 0, report only after hold
    pins_n = 5'b11110;
    wait_ticks(HOLD - 10);
    check(got.size() == 0, "R2", "no report before hold", got.size(), 0);
    wait_ticks(20);
    check(got.size() == 1, "R2", "one report after hold", got.size(), 1);
    if (got.size() == 1)
      check(got[0] == 8'h01, "R1", "reported word", got[0], 8'h01);

    // R3: bouncing between two values, settles at 0x03
    n0 = got.size();
    for (int i = 0; i < 5; i++) begin
      pins_n = 5'b11100; wait_ticks(30);
      pins_n = 5'b11110; wait_ticks(30);
    end
    pins_n = 5'b11100;
    check(got.size() == n0, "R3", "no report while bouncing", got.size(), n0);
    wait_ticks(HOLD + 10);
    check(got.size() == n0 + 1, "R3", "single settled report", got.size(), n0 + 1);
    if (got.size() == n0 + 1)
      check(got[n0] == 8'h03, "R3", "settled value", got[n0], 8'h03);

    // R4: leave and return before settling
    n0 = got.size();
    pins_n = 5'b00000; wait_ticks(40);
    pins_n = 5'b11100; wait_ticks(HOLD + 20);
    check(got.size() == n0, "R4", "no report for same value", got.size(), n0);

    // R5 query
    send(8'h3F);
    check(got.size() == n0 + 1, "R5", "query reply count", got.size(), n0 + 1);
    if (got.size() == n0 + 1)
      check(got[n0] == 8'h03, "R5", "query reply value", got[n0], 8'h03);

    // R6 / R7 outputs
    send(8'h61); check(drv_n == 2'b10, "R6", "a", drv_n, 2);
    send(8'h62); check(drv_n == 2'b00, "R7", "b", drv_n, 0);
    send(8'h41); check(drv_n == 2'b01, "R6", "A", drv_n, 1);
    send(8'h42); check(drv_n == 2'b11, "R7", "B", drv_n, 3);
    send(8'h62);

    // R9 ignored bytes
    n0 = got.size();
    send(8'h63); send(8'h78); send(8'h00); send(8'hFF); send(8'h3E);
    check(drv_n == 2'b01, "R9", "drv_n unchanged", drv_n, 1);
    check(got.size() == n0, "R9", "nothing sent", got.size(), n0);

    // R11 / R13 backpressure
    tx_ready = 1'b0;
    send(8'h3F);
    repeat (10) @(negedge clk);
    check(tx_valid && tx_data == 8'h03, "R11", "held byte", tx_data, 8'h03);
    check(!rx_ready, "R13", "rx_ready while pending", int'(rx_ready), 0);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);

    // R10 report and query in the same cycle
    tx_ready = 1'b0;
    pins_n = 5'b00000;
    @(negedge clk);
    while (!(m_cnt == 0 && m_prev != m_rep && mq.size() == 0)) @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h3F;
    @(negedge clk);
    rx_valid = 1'b0;
    check(!rx_ready, "R10", "queue full, rx_ready low", int'(rx_ready), 0);
    check(tx_valid && tx_data == 8'h1F, "R10", "report first", tx_data, 8'h1F);
    n0 = got.size();
    tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(got.size() == n0 + 2, "R10", "two bytes drained", got.size(), n0 + 2);
    if (got.size() == n0 + 2)
      check(got[n0+1] == 8'h1F, "R10", "reply value", got[n0+1], 8'h1F);
    foreach (got[i])
      check(got[i][7:5] == 3'b000, "R1", "upper bits zero", got[i], got[i] & 8'h1F);

    finish_run();
  end
endmodule